// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word addresses for a multi-word memory operation: a multi-register load, a multi-register store, or a copy from one memory region to another. It is given a base address (or two, for a copy), a word count and an operation code. It then presents one word address per cycle on a read channel, a write channel, or both. A downstream ready signal can hold it in place for any number of cycles.

The block also reduces lookup work in the memory pipeline. For each channel it asks for a cache tag lookup only on the first word and whenever the stream enters a new cache line. It asks for a translation lookup only on the first word and whenever the stream enters a new page. On every other word the memory unit reuses the line and translation it already resolved. A one-cycle completion pulse follows the last word.

Top module: `blkxfer_seq`

## Requirements
- R1: Operation code 2'b00 (load) drives only the read channel, starting at `src_addr`. Code 2'b01 (store) drives only the write channel, starting at `dst_addr`. Code 2'b10 (copy) drives both channels in the same cycles, reading from `src_addr` and writing to `dst_addr`.
- R2: A start is taken only while `busy` is low. The first word appears in the cycle after the accepting edge. Word i carries the base address with its three low bits cleared, plus 8*i.
- R3: While `ready` is high, one word is issued on every rising edge. A word counts as issued on an edge where its valid is high and `ready` is high.
- R4: A channel's tag request is high on its first word and on any word whose address is a multiple of 64. It is low on every other word and whenever the channel is not valid.
- R5: A channel's translation request is high on its first word and on any word whose address is a multiple of 4096. It is low otherwise.
- R6: During a copy, the read and write channels detect line and page entry separately, each from its own address.
- R7: While `busy` is high and `ready` is low, the addresses, the requests and `busy` hold their values into the next cycle.
- R8: `done` is high for exactly one cycle: the cycle after the edge that issues the last word. `busy` is low in that cycle.
- R9: A start with a count of zero raises `done` in the next cycle. It raises no valid and no request.
- R10: A start with operation code 2'b11 is ignored. Neither `busy` nor `done` rises.
- R11: A start that arrives while `busy` is high is ignored. The transfer in progress continues unchanged.
- R12: After reset, `busy`, `done`, both valids and all four requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new transfer |
| op | input | 2 | Operation code: 00 load, 01 store, 10 copy, 11 reserved |
| src_addr | input | AW | Read base address |
| dst_addr | input | AW | Write base address |
| count | input | CW | Number of words |
| ready | input | 1 | Memory pipeline accepts the current word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read word address valid |
| rd_addr | output | AW | Read word address |
| rd_tag_req | output | 1 | Read channel needs a tag lookup |
| rd_tlb_req | output | 1 | Read channel needs a translation lookup |
| wr_valid | output | 1 | Write word address valid |
| wr_addr | output | AW | Write word address |
| wr_tag_req | output | 1 | Write channel needs a tag lookup |
| wr_tlb_req | output | 1 | Write channel needs a translation lookup |

## Verification
Addresses and requests for the first word appear one cycle after the start edge. Each later word appears one cycle after the edge that issued the word before it. `done` appears one cycle after the edge that issues the last word, or one cycle after a start with a zero count. The scoreboard compares a word only at the falling edge where both its valid and `ready` are high, so it compares exactly the words that the next rising edge will issue. The driver checks `done` just after the rising edge that empties the queue, and again one cycle later to confirm that `done` has dropped.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_COPY  = 2'b10,
    OP_RSVD  = 2'b11
  } xfer_op_e;

  // True when addr falls on a multiple of span (span a power of two)
  function automatic logic on_boundary(input logic [63:0] addr, input int unsigned span);
    logic [63:0] mask;
    mask = 64'(span) - 64'd1;
    return (addr & mask) == 64'd0;
  endfunction

  function automatic logic uses_read(input xfer_op_e o);
    return (o == OP_LOAD) || (o == OP_COPY);
  endfunction

  function automatic logic uses_write(input xfer_op_e o);
    return (o == OP_STORE) || (o == OP_COPY);
  endfunction

endpackage

// File: rtl/blkxfer_stream.sv
module blkxfer_stream
  import blkxfer_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          line_entry,
  output logic          page_entry
);
  localparam int WLSB = $clog2(WORD_BYTES);

  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      first_q <= 1'b0;
    end else if (load) begin
      addr    <= {base[AW-1:WLSB], {WLSB{1'b0}}};
      first_q <= 1'b1;
    end else if (advance) begin
      addr    <= addr + AW'(WORD_BYTES);
      first_q <= 1'b0;
    end
  end

  always_comb begin
    line_entry = first_q || on_boundary(64'(addr), LINE_BYTES);
    page_entry = first_q || on_boundary(64'(addr), PAGE_BYTES);
  end

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  xfer_op_e      op,
  input  logic [CW-1:0] count,
  input  logic          ready,
  output logic          busy,
  output xfer_op_e      op_q,
  output logic          load,
  output logic          advance,
  output logic          done
);
  logic [CW-1:0] remaining;
  logic          accept;
  logic          last_issue;

  always_comb begin
    accept     = start && !busy && (op != OP_RSVD);
    load       = accept && (count != '0);
    advance    = busy && ready;
    last_issue = advance && (remaining == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
      op_q      <= OP_LOAD;
    end else begin
      done <= (accept && (count == '0)) || last_issue;
      if (load) begin
        busy      <= 1'b1;
        remaining <= count;
        op_q      <= op;
      end else if (advance) begin
        remaining <= remaining - CW'(1);
        if (last_issue) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] count,
  input  logic          ready,
  output logic          busy,
  output logic          done,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic          rd_tag_req,
  output logic          rd_tlb_req,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic          wr_tag_req,
  output logic          wr_tlb_req
);
  localparam int NCH = 2;  // channel 0 reads, channel 1 writes

  xfer_op_e op_q;
  logic     load, advance;

  blkxfer_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(xfer_op_e'(op)),
    .count(count), .ready(ready), .busy(busy), .op_q(op_q),
    .load(load), .advance(advance), .done(done)
  );

  logic [AW-1:0] base_v [NCH];
  logic [AW-1:0] addr_v [NCH];
  logic [NCH-1:0] line_v, page_v, used_v;

  always_comb begin
    base_v[0] = src_addr;
    base_v[1] = dst_addr;
    used_v[0] = busy && uses_read(op_q);
    used_v[1] = busy && uses_write(op_q);
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    blkxfer_stream #(
      .AW(AW), .WORD_BYTES(WORD_BYTES),
      .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
    ) u_strm (
      .clk(clk), .rst_n(rst_n), .load(load), .base(base_v[ch]),
      .advance(advance), .addr(addr_v[ch]),
      .line_entry(line_v[ch]), .page_entry(page_v[ch])
    );
  end

  always_comb begin
    rd_valid   = used_v[0];
    rd_addr    = addr_v[0];
    rd_tag_req = used_v[0] && line_v[0];
    rd_tlb_req = used_v[0] && page_v[0];
    wr_valid   = used_v[1];
    wr_addr    = addr_v[1];
    wr_tag_req = used_v[1] && line_v[1];
    wr_tlb_req = used_v[1] && page_v[1];
  end

endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int WORD_BYTES = 8,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    op,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] count,
  input logic          ready,
  input logic          busy,
  input logic          done,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_tag_req,
  input logic          rd_tlb_req,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic          wr_tag_req,
  input logic          wr_tlb_req
);
  localparam int LLSB = $clog2(LINE_BYTES);
  localparam int PLSB = $clog2(PAGE_BYTES);

  wire rd_issue = rd_valid && ready;
  wire wr_issue = wr_valid && ready;

  a_r4_rd_same_line_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue && busy ##1 rd_valid && (rd_addr[AW-1:LLSB] == $past(rd_addr[AW-1:LLSB]))
      |-> !rd_tag_req);

  a_r6_wr_same_line_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_issue && busy ##1 wr_valid && (wr_addr[AW-1:LLSB] == $past(wr_addr[AW-1:LLSB]))
      |-> !wr_tag_req);

  a_r5_rd_same_page_no_tlb: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue && busy ##1 rd_valid && (rd_addr[AW-1:PLSB] == $past(rd_addr[AW-1:PLSB]))
      |-> !rd_tlb_req);

  a_r4_req_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_tag_req || rd_tlb_req) |-> rd_valid);

  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !ready |=> busy && $stable(rd_addr) && $stable(wr_addr) && $stable(rd_tag_req));

  a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> !rd_valid || (rd_addr == $past(rd_addr) + AW'(WORD_BYTES)));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !rd_valid && !wr_valid);

endmodule

bind blkxfer_seq blkxfer_seq_chk #(
  .AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES),
  .LINE_BYTES(LINE_BYTES), .PAGE_BYTES(PAGE_BYTES)
) u_chk (.*);

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/100ps
module blkxfer_seq_tb;
  localparam int AW = 32;
  localparam int CW = 16;

  typedef struct {
    logic          rv;
    logic [AW-1:0] ra;
    logic          rtag, rtlb;
    logic          wv;
    logic [AW-1:0] wa;
    logic          wtag, wtlb;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ready = 1'b1;
  logic [1:0] op = 2'b00;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [CW-1:0] count = '0;
  logic busy, done, rd_valid, rd_tag_req, rd_tlb_req, wr_valid, wr_tag_req, wr_tlb_req;
  logic [AW-1:0] rd_addr, wr_addr;

  int checks = 0, fails = 0;
  item_t exp_q[$];
  logic stall_en = 1'b0;
  logic [7:0] lfsr = 8'h5A;

  always #2.5 clk = ~clk;

  blkxfer_seq u_dut (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stall pattern changes just after each rising edge
  always @(posedge clk) begin
    #1;
    if (stall_en) begin
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ready = lfsr[0] | lfsr[2];
    end else ready = 1'b1;
  end

  // monitor: compare each word about to be issued
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_ra, prev_wa;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(busy && rd_addr == prev_ra && wr_addr == prev_wa, "R7 hold", {rd_addr, wr_addr}, {prev_ra, prev_wa});
      end
      prev_stall = busy && !ready;
      prev_ra    = rd_addr;
      prev_wa    = wr_addr;
      if ((rd_valid || wr_valid) && ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected word", 64'(rd_addr), 64'd0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(rd_valid == e.rv && wr_valid == e.wv, "R1 channel valids", {rd_valid, wr_valid}, {e.rv, e.wv});
          if (e.rv) chk(rd_addr == e.ra, "R2 read address", 64'(rd_addr), 64'(e.ra));
          if (e.wv) chk(wr_addr == e.wa, "R2 write address", 64'(wr_addr), 64'(e.wa));
          chk(rd_tag_req == e.rtag && wr_tag_req == e.wtag, "R4 R6 tag requests",
              {rd_tag_req, wr_tag_req}, {e.rtag, e.wtag});
          chk(rd_tlb_req == e.rtlb && wr_tlb_req == e.wtlb, "R5 R6 translation requests",
              {rd_tlb_req, wr_tlb_req}, {e.rtlb, e.wtlb});
        end
      end
    end
  end

  task automatic push_words(input logic [1:0] o, input logic [AW-1:0] s, input logic [AW-1:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      item_t e;
      logic [AW-1:0] a, b;
      a = (s & ~AW'(7)) + AW'(8 * i);
      b = (d & ~AW'(7)) + AW'(8 * i);
      e.rv = (o == 2'b00) || (o == 2'b10);
      e.wv = (o == 2'b01) || (o == 2'b10);
      e.ra = a;
      e.wa = b;
      e.rtag = e.rv && (i == 0 || a % 64 == 0);
      e.rtlb = e.rv && (i == 0 || a % 4096 == 0);
      e.wtag = e.wv && (i == 0 || b % 64 == 0);
      e.wtlb = e.wv && (i == 0 || b % 4096 == 0);
      exp_q.push_back(e);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [AW-1:0] s, input logic [AW-1:0] d,
                     input int n, input logic poke);
    push_words(o, s, d, n);
    @(posedge clk); #1;
    start = 1'b1; op = o; src_addr = s; dst_addr = d; count = CW'(n);
    @(posedge clk); #1;
    start = 1'b0;
    if (n == 0) begin
      chk(done && !busy && !rd_valid && !wr_valid && !rd_tag_req && !wr_tlb_req,
          "R9 zero count done", {done, busy, rd_valid, wr_valid}, 4'b1000);
    end else begin
      fork
        while (exp_q.size() != 0) begin @(posedge clk); #1; end
        if (poke) begin
          repeat (2) @(posedge clk);
          #1.2;
          start = 1'b1; op = 2'b00; src_addr = 32'h0000_F000; count = CW'(1);
          @(posedge clk); #1.2;
          start = 1'b0; op = o; src_addr = s; count = CW'(n);
        end
      join
      chk(done && !busy, "R8 done after last word", {done, busy}, 2'b10);
    end
    @(posedge clk); #1;
    chk(!done, "R8 done lasts one cycle", done, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_valid && !wr_valid && !rd_tag_req && !rd_tlb_req
        && !wr_tag_req && !wr_tlb_req, "R12 reset state", {busy, done, rd_valid, wr_valid}, 0);

    run(2'b00, 32'h0000_1030, 32'h0, 10, 1'b0);        // R1 R3 load crossing a line
    run(2'b00, 32'h0000_2208, 32'h0, 1, 1'b0);         // single word
    stall_en = 1'b1;
    run(2'b01, 32'h0, 32'h0000_1FF0, 6, 1'b0);         // R1 R5 store crossing a page, stalls
    run(2'b10, 32'h0000_0FC8, 32'h0000_3000, 20, 1'b0); // R6 copy, independent streams
    run(2'b10, 32'h0000_5FFD, 32'h0000_7F38, 12, 1'b1); // R2 unaligned base, R11 poke
    stall_en = 1'b0;
    run(2'b00, 32'h0000_4000, 32'h0, 0, 1'b0);         // R9 zero count

    // R10 reserved code ignored
    @(posedge clk); #1;
    start = 1'b1; op = 2'b11; count = CW'(4);
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy && !done && !rd_valid && !wr_valid, "R10 reserved op ignored",
          {busy, done, rd_valid, wr_valid}, 0);
    end
    chk(exp_q.size() == 0, "R3 all words issued", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule